// File: doc/BRIEF.md
# Data Access Translation Checker

This block sits after the translation lookaside buffer on the data side of a processor core. It takes one data request per cycle, together with the processor state bits, the two context registers and the lookup result for that request. It then decides the outcome. The outcome is either a physical address, or exactly one fault, or a translation bypass for the most privileged modes. It also selects the context that applies to the access. For a miss, it prepares the word that the refill handler reads to find the missing page.

The checks run in a fixed order, and the first one that fails decides the result:

1. mode bypass
2. alignment
3. address hole
4. lookup miss
5. write protection
6. no-fault page
7. privilege

A fault drives write strobes and data for the fault status register and the fault address register. A miss drives the tag-access register instead. All results are registered, so the response appears one clock after the request.

Top module: `dxlate_check`

## Requirements
- R1: During reset and in the first cycle after reset ends with no request, `rsp_valid`, `fsr_we`, `tag_we`, `rsp_uncache` and `rsp_fault` are all zero.
- R2: When `st_hpriv` or `st_red` is 1, no check is made. The response has `rsp_fault`=0 and `rsp_pa` equal to the low PA_W bits of `req_va`, even if the request is misaligned or misses.
- R3: The context is zero with kind code 2 (nucleus) when `st_tl_nz` or `asi_nucleus` is 1. Otherwise it is `ctx_secondary` with kind code 1 when `asi_secondary` is 1. Otherwise it is `ctx_primary` with kind code 0. The kind code appears on `fsr_ctx`.
- R4: The access size is 2^`req_size` bytes. A nonzero `req_va` AND (size−1) gives fault code 1 with `fsr_type`=0, `fsr_se`=0 and `far_addr`=`req_va`.
- R5: When `st_am` is 1, bits VA_W−1..32 of the address are cleared before the range check and all later steps. An unmasked address from 0x0000_8000_0000_0000 to 0xFFFF_7FFF_FFFF_FFFF gives fault code 2 with `fsr_type`=1 and `fsr_se`=1.
- R6: A miss gives code 3 if `asi_real` is 1 or `mmu_en` is 0, and code 4 otherwise. A miss writes `tag_wdata` = (checked address with bits 12..0 cleared) OR context. A miss does not write the fault status register.
- R7: A write to an entry with `tlb_w`=0 gives code 5 with `fsr_type`=0 and `fsr_se`=`tlb_se`.
- R8: A hit on an entry with `tlb_nf`=1 when `asi_nofault` is 0 gives code 6 with `fsr_type`=2.
- R9: A hit on an entry with `tlb_priv`=1 when `st_priv` is 0 gives code 7 with `fsr_type`=3.
- R10: `rsp_uncache` is 1 only for a fault-free hit on an entry with `tlb_se`=1.
- R11: On a fault-free hit, `rsp_pa` = (`tlb_pa` with offset bits cleared) OR (offset bits of the address). The offset width is 13, 16, 22 or 28 bits for `tlb_pgsz` 0, 1, 2 or 3.
- R12: Only the earliest failing check in the order bypass, alignment, hole, miss, protection, no-fault, privilege is reported. On any fault, `rsp_pa` is 0.
- R13: The response comes one cycle after `req_valid`. Every fault except a miss raises `fsr_we` with `fsr_write`=`req_wr`, `fsr_asi`=`req_asi` and `far_addr`. Without a request, all strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | VA_W | Virtual address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_wr | input | 1 | Store access |
| req_asi | input | ASI_W | Address space identifier, recorded on faults |
| asi_nucleus | input | 1 | ASI class: nucleus |
| asi_secondary | input | 1 | ASI class: secondary context |
| asi_real | input | 1 | ASI class: real address |
| asi_nofault | input | 1 | ASI class: no-fault |
| st_hpriv | input | 1 | Hyperprivileged mode |
| st_red | input | 1 | Reset/error state |
| st_priv | input | 1 | Privileged mode |
| st_am | input | 1 | 32-bit address masking |
| st_tl_nz | input | 1 | Trap level above zero |
| mmu_en | input | 1 | Data translation enabled |
| ctx_primary | input | CTX_W | Primary context |
| ctx_secondary | input | CTX_W | Secondary context |
| tlb_hit | input | 1 | Lookup hit |
| tlb_pa | input | PA_W | Entry physical address |
| tlb_pgsz | input | 2 | Entry page size code |
| tlb_w | input | 1 | Entry writable |
| tlb_nf | input | 1 | Entry is a no-fault page |
| tlb_se | input | 1 | Entry has side effects |
| tlb_priv | input | 1 | Entry privileged only |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | PA_W | Physical address |
| rsp_uncache | output | 1 | Request is uncacheable |
| rsp_fault | output | 3 | Fault code, 0 for none |
| fsr_we | output | 1 | Fault status and fault address write strobe |
| fsr_write | output | 1 | Status: faulting access was a store |
| fsr_ctx | output | 2 | Status: context kind |
| fsr_se | output | 1 | Status: side-effect bit |
| fsr_type | output | 2 | Status: fault type |
| fsr_asi | output | ASI_W | Status: ASI of the faulting access |
| far_addr | output | VA_W | Faulting address |
| tag_we | output | 1 | Tag-access write strobe |
| tag_wdata | output | VA_W | Tag-access value on a miss |

## Verification
The assertions assume that the lookup inputs are steady and meaningful whenever `req_valid` is high. They also assume that at most one of the context-select class bits matters at a time, because the nucleus selection wins. The stimulus meets these assumptions. Every scenario starts from a default state: a benign hit, a writable and unprivileged entry, and translation enabled. It then changes only the inputs that the scenario needs. Each request lasts a single cycle, and inputs are set on the falling edge.

// File: rtl/dxlate_check.sv
module dxlate_check #(
  parameter int VA_W = 64,
  parameter int PA_W = 40,
  parameter int CTX_W = 13,
  parameter int ASI_W = 8,
  parameter int AM_W = 32,
  parameter int BASE_PG = 13,
  parameter logic [VA_W-1:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_size,
  input  logic             req_wr,
  input  logic [ASI_W-1:0] req_asi,
  input  logic             asi_nucleus,
  input  logic             asi_secondary,
  input  logic             asi_real,
  input  logic             asi_nofault,
  input  logic             st_hpriv,
  input  logic             st_red,
  input  logic             st_priv,
  input  logic             st_am,
  input  logic             st_tl_nz,
  input  logic             mmu_en,
  input  logic [CTX_W-1:0] ctx_primary,
  input  logic [CTX_W-1:0] ctx_secondary,
  input  logic             tlb_hit,
  input  logic [PA_W-1:0]  tlb_pa,
  input  logic [1:0]       tlb_pgsz,
  input  logic             tlb_w,
  input  logic             tlb_nf,
  input  logic             tlb_se,
  input  logic             tlb_priv,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_uncache,
  output logic [2:0]       rsp_fault,
  output logic             fsr_we,
  output logic             fsr_write,
  output logic [1:0]       fsr_ctx,
  output logic             fsr_se,
  output logic [1:0]       fsr_type,
  output logic [ASI_W-1:0] fsr_asi,
  output logic [VA_W-1:0]  far_addr,
  output logic             tag_we,
  output logic [VA_W-1:0]  tag_wdata
);

  localparam logic [2:0] F_NONE  = 3'd0;
  localparam logic [2:0] F_ALIGN = 3'd1;
  localparam logic [2:0] F_RANGE = 3'd2;
  localparam logic [2:0] F_RMISS = 3'd3;
  localparam logic [2:0] F_VMISS = 3'd4;
  localparam logic [2:0] F_PROT  = 3'd5;
  localparam logic [2:0] F_NFO   = 3'd6;
  localparam logic [2:0] F_PRIV  = 3'd7;

  localparam logic [1:0] T_OTHER = 2'd0;
  localparam logic [1:0] T_RANGE = 2'd1;
  localparam logic [1:0] T_NFO   = 2'd2;
  localparam logic [1:0] T_PRIV  = 2'd3;

  localparam logic [VA_W-1:0] AM_MASK  = {{(VA_W-AM_W){1'b0}}, {AM_W{1'b1}}};
  localparam logic [VA_W-1:0] PG_CLEAR = {VA_W{1'b1}} << BASE_PG;

  logic [VA_W-1:0]  va_eff;
  logic [2:0]       size_m1;
  logic             misalign, in_hole, bypass, use_real;
  logic [1:0]       ctx_kind;
  logic [CTX_W-1:0] ctx_val;
  logic [4:0]       off_bits;
  logic [PA_W-1:0]  pg_mask;

  assign va_eff   = st_am ? (req_va & AM_MASK) : req_va;
  assign size_m1  = 3'((4'd1 << req_size) - 4'd1);
  assign misalign = |(req_va[2:0] & size_m1);
  assign in_hole  = (va_eff >= HOLE_LO) && (va_eff <= HOLE_HI);
  assign bypass   = st_hpriv | st_red;
  assign use_real = asi_real | ~mmu_en;

  always_comb begin
    if (st_tl_nz || asi_nucleus) begin
      ctx_kind = 2'd2;
      ctx_val  = '0;
    end else if (asi_secondary) begin
      ctx_kind = 2'd1;
      ctx_val  = ctx_secondary;
    end else begin
      ctx_kind = 2'd0;
      ctx_val  = ctx_primary;
    end
  end

  always_comb begin
    case (tlb_pgsz)
      2'd0:    off_bits = 5'd13;
      2'd1:    off_bits = 5'd16;
      2'd2:    off_bits = 5'd22;
      default: off_bits = 5'd28;
    endcase
  end
  assign pg_mask = ~({PA_W{1'b1}} << off_bits);

  logic [2:0]      n_fault;
  logic [1:0]      n_type;
  logic            n_se, n_fsr, n_tag, n_unc;
  logic [PA_W-1:0] n_pa;
  logic [VA_W-1:0] n_far;

  always_comb begin
    n_fault = F_NONE;
    n_type  = T_OTHER;
    n_se    = 1'b0;
    n_fsr   = 1'b0;
    n_tag   = 1'b0;
    n_unc   = 1'b0;
    n_pa    = '0;
    n_far   = va_eff;
    if (bypass) begin
      n_pa = req_va[PA_W-1:0];
    end else if (misalign) begin
      n_fault = F_ALIGN;
      n_fsr   = 1'b1;
      n_far   = req_va;
    end else if (in_hole) begin
      n_fault = F_RANGE;
      n_type  = T_RANGE;
      n_se    = 1'b1;
      n_fsr   = 1'b1;
    end else if (!tlb_hit) begin
      n_fault = use_real ? F_RMISS : F_VMISS;
      n_tag   = 1'b1;
    end else if (req_wr && !tlb_w) begin
      n_fault = F_PROT;
      n_se    = tlb_se;
      n_fsr   = 1'b1;
    end else if (tlb_nf && !asi_nofault) begin
      n_fault = F_NFO;
      n_type  = T_NFO;
      n_se    = tlb_se;
      n_fsr   = 1'b1;
    end else if (!st_priv && tlb_priv) begin
      n_fault = F_PRIV;
      n_type  = T_PRIV;
      n_se    = tlb_se;
      n_fsr   = 1'b1;
    end else begin
      n_pa  = (tlb_pa & ~pg_mask) | (va_eff[PA_W-1:0] & pg_mask);
      n_unc = tlb_se;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_pa      <= '0;
      rsp_uncache <= 1'b0;
      rsp_fault   <= F_NONE;
      fsr_we      <= 1'b0;
      fsr_write   <= 1'b0;
      fsr_ctx     <= '0;
      fsr_se      <= 1'b0;
      fsr_type    <= T_OTHER;
      fsr_asi     <= '0;
      far_addr    <= '0;
      tag_we      <= 1'b0;
      tag_wdata   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_pa      <= req_valid ? n_pa : '0;
      rsp_uncache <= req_valid & n_unc;
      rsp_fault   <= req_valid ? n_fault : F_NONE;
      fsr_we      <= req_valid & n_fsr;
      tag_we      <= req_valid & n_tag;
      if (req_valid && n_fsr) begin
        fsr_write <= req_wr;
        fsr_ctx   <= ctx_kind;
        fsr_se    <= n_se;
        fsr_type  <= n_type;
        fsr_asi   <= req_asi;
        far_addr  <= n_far;
      end
      if (req_valid && n_tag)
        tag_wdata <= (va_eff & PG_CLEAR) | VA_W'(ctx_val);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!fsr_we && !tag_we && !rsp_uncache && rsp_fault == F_NONE)); // R13
  AST_TAG_ONLY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> (rsp_fault == F_RMISS || rsp_fault == F_VMISS) && !fsr_we); // R6
  AST_STATUS_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != F_NONE && !tag_we) |-> fsr_we); // R13
  AST_UNCACHE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncache |-> (rsp_valid && rsp_fault == F_NONE)); // R10
  AST_PA_ZERO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != F_NONE) |-> (rsp_pa == '0)); // R12
  AST_RANGE_SE: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_we && rsp_fault == F_RANGE) |-> (fsr_se && fsr_type == T_RANGE)); // R5

endmodule

// File: tb/dxlate_check_tb.sv
module dxlate_check_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid, req_wr, asi_nucleus, asi_secondary, asi_real, asi_nofault;
  logic [63:0] req_va;
  logic [1:0]  req_size, tlb_pgsz;
  logic [7:0]  req_asi;
  logic        st_hpriv, st_red, st_priv, st_am, st_tl_nz, mmu_en;
  logic [12:0] ctx_primary, ctx_secondary;
  logic        tlb_hit, tlb_w, tlb_nf, tlb_se, tlb_priv;
  logic [39:0] tlb_pa;
  logic        rsp_valid, rsp_uncache, fsr_we, fsr_write, fsr_se, tag_we;
  logic [39:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic [1:0]  fsr_ctx, fsr_type;
  logic [7:0]  fsr_asi;
  logic [63:0] far_addr, tag_wdata;

  dxlate_check u_dut (.*);

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    req_valid = 0; req_va = 64'h1000; req_size = 2'd3; req_wr = 0; req_asi = 8'h80;
    asi_nucleus = 0; asi_secondary = 0; asi_real = 0; asi_nofault = 0;
    st_hpriv = 0; st_red = 0; st_priv = 0; st_am = 0; st_tl_nz = 0; mmu_en = 1;
    ctx_primary = 13'h055; ctx_secondary = 13'h1AA;
    tlb_hit = 1; tlb_pa = 40'h12_0000_0000; tlb_pgsz = 0; tlb_w = 1; tlb_nf = 0; tlb_se = 0; tlb_priv = 0;
  endtask

  task automatic fire();
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 valid", 64'(rsp_valid), 0);
    chk("R1 fsr_we", 64'(fsr_we), 0);
    chk("R1 tag_we", 64'(tag_we), 0);
    chk("R1 fault", 64'(rsp_fault), 0);
    chk("R1 uncache", 64'(rsp_uncache), 0);
  endtask

  task automatic t_bypass();
    defaults(); st_hpriv = 1; req_va = 64'h0000_00AB_CDEF_1235; tlb_hit = 0; fire();
    chk("R2 hpriv fault", 64'(rsp_fault), 0);
    chk("R2 hpriv pa", 64'(rsp_pa), 64'hAB_CDEF_1235);
    chk("R2 hpriv tag_we", 64'(tag_we), 0);
    defaults(); st_red = 1; req_va = 64'hFFFF_0000_0000_0003; fire();
    chk("R2 red fault", 64'(rsp_fault), 0);
    chk("R2 red pa", 64'(rsp_pa), 64'h00_0000_0003);
  endtask

  task automatic t_align();
    defaults(); req_size = 2; req_va = 64'h0000_0000_0000_4002; req_wr = 1; req_asi = 8'h21; fire();
    chk("R4 code", 64'(rsp_fault), 1);
    chk("R4 type", 64'(fsr_type), 0);
    chk("R4 se", 64'(fsr_se), 0);
    chk("R4 far", far_addr, 64'h4002);
    chk("R13 fsr_we", 64'(fsr_we), 1);
    chk("R13 write", 64'(fsr_write), 1);
    chk("R13 asi", 64'(fsr_asi), 8'h21);
    defaults(); req_size = 0; req_va = 64'h4003; fire();
    chk("R4 byte ok", 64'(rsp_fault), 0);
  endtask

  task automatic t_hole();
    defaults(); req_va = 64'h0000_8000_0000_0000; fire();
    chk("R5 code", 64'(rsp_fault), 2);
    chk("R5 type", 64'(fsr_type), 1);
    chk("R5 se", 64'(fsr_se), 1);
    chk("R5 far", far_addr, 64'h0000_8000_0000_0000);
    defaults(); req_va = 64'hFFFF_7FFF_FFFF_FFF8; fire();
    chk("R5 top edge", 64'(rsp_fault), 2);
    defaults(); req_va = 64'hFFFF_8000_0000_0000; fire();
    chk("R5 above hole", 64'(rsp_fault), 0);
    defaults(); st_am = 1; req_va = 64'h0000_8000_0000_1238; fire();
    chk("R5 am no fault", 64'(rsp_fault), 0);
    chk("R5 am pa", 64'(rsp_pa), 64'h12_0000_1238);
  endtask

  task automatic t_miss();
    defaults(); tlb_hit = 0; req_va = 64'h0000_0000_1234_5678; fire();
    chk("R6 vmiss", 64'(rsp_fault), 4);
    chk("R6 tag_we", 64'(tag_we), 1);
    chk("R6 tag primary", tag_wdata, 64'h1234_4055);
    chk("R6 no fsr", 64'(fsr_we), 0);
    defaults(); tlb_hit = 0; asi_secondary = 1; req_va = 64'h0000_0000_1234_5678; fire();
    chk("R3 tag secondary", tag_wdata, 64'h1234_41AA);
    defaults(); tlb_hit = 0; st_tl_nz = 1; asi_secondary = 1; req_va = 64'h0000_0000_1234_5678; fire();
    chk("R3 tag nucleus", tag_wdata, 64'h1234_4000);
    defaults(); tlb_hit = 0; asi_real = 1; fire();
    chk("R6 real miss", 64'(rsp_fault), 3);
    defaults(); tlb_hit = 0; mmu_en = 0; fire();
    chk("R6 mmu off miss", 64'(rsp_fault), 3);
    defaults(); tlb_hit = 0; st_am = 1; req_va = 64'hFFFF_FFFF_8765_4321; req_size = 0; fire();
    chk("R5 am tag", tag_wdata, 64'h8765_4055);
  endtask

  task automatic t_prot();
    defaults(); req_wr = 1; tlb_w = 0; tlb_se = 1; fire();
    chk("R7 code", 64'(rsp_fault), 5);
    chk("R7 se", 64'(fsr_se), 1);
    chk("R7 type", 64'(fsr_type), 0);
    chk("R10 no uncache on fault", 64'(rsp_uncache), 0);
    defaults(); tlb_w = 0; fire();
    chk("R7 read ok", 64'(rsp_fault), 0);
  endtask

  task automatic t_nfo();
    defaults(); tlb_nf = 1; fire();
    chk("R8 code", 64'(rsp_fault), 6);
    chk("R8 type", 64'(fsr_type), 2);
    defaults(); tlb_nf = 1; asi_nofault = 1; fire();
    chk("R8 nf asi ok", 64'(rsp_fault), 0);
  endtask

  task automatic t_priv();
    defaults(); tlb_priv = 1; fire();
    chk("R9 code", 64'(rsp_fault), 7);
    chk("R9 type", 64'(fsr_type), 3);
    chk("R3 ctx primary", 64'(fsr_ctx), 0);
    defaults(); tlb_priv = 1; asi_secondary = 1; fire();
    chk("R3 ctx secondary", 64'(fsr_ctx), 1);
    defaults(); tlb_priv = 1; asi_nucleus = 1; asi_secondary = 1; fire();
    chk("R3 ctx nucleus", 64'(fsr_ctx), 2);
    defaults(); tlb_priv = 1; st_priv = 1; fire();
    chk("R9 priv ok", 64'(rsp_fault), 0);
  endtask

  task automatic t_uncache();
    defaults(); tlb_se = 1; fire();
    chk("R10 uncache", 64'(rsp_uncache), 1);
    defaults(); fire();
    chk("R10 cacheable", 64'(rsp_uncache), 0);
  endtask

  task automatic t_pa();
    defaults(); tlb_pa = 40'hAA_AAAA_AAAA; req_va = 64'h0555_5555; req_size = 0;
    tlb_pgsz = 0; fire(); chk("R11 8k", 64'(rsp_pa), 64'hAA_AAAA_B555);
    tlb_pgsz = 1; fire(); chk("R11 64k", 64'(rsp_pa), 64'hAA_AAAA_5555);
    tlb_pgsz = 2; fire(); chk("R11 4m", 64'(rsp_pa), 64'hAA_AA95_5555);
    tlb_pgsz = 3; fire(); chk("R11 256m", 64'(rsp_pa), 64'hAA_A555_5555);
  endtask

  task automatic t_priority();
    defaults(); req_va = 64'h0000_8000_0000_0001; tlb_hit = 0; fire();
    chk("R12 align first", 64'(rsp_fault), 1);
    chk("R12 pa zero", 64'(rsp_pa), 0);
    defaults(); req_va = 64'h0000_8000_0000_0000; tlb_hit = 0; fire();
    chk("R12 hole before miss", 64'(rsp_fault), 2);
    chk("R12 no tag", 64'(tag_we), 0);
    defaults(); req_wr = 1; tlb_w = 0; tlb_nf = 1; tlb_priv = 1; fire();
    chk("R12 prot first", 64'(rsp_fault), 5);
    defaults(); tlb_nf = 1; tlb_priv = 1; fire();
    chk("R12 nfo before priv", 64'(rsp_fault), 6);
  endtask

  task automatic t_idle();
    defaults(); tlb_hit = 0; @(negedge clk);
    chk("R13 idle valid", 64'(rsp_valid), 0);
    chk("R13 idle tag", 64'(tag_we), 0);
    defaults(); fire();
    chk("R13 one cycle valid", 64'(rsp_valid), 1);
    @(negedge clk);
    chk("R13 drops", 64'(rsp_valid), 0);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_align();
    t_hole();
    t_miss();
    t_prot();
    t_nfo();
    t_priv();
    t_uncache();
    t_pa();
    t_priority();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule